// File: doc/BRIEF.md
# Pointer-Update Address Generator

This block forms the byte address for a register-indirect load or store, together with the value that the base pointer register should hold afterwards. It takes a 32-bit pointer value and an unsigned offset. The offset is counted in elements, so the block scales it by the access width. A mode code chooses one of four behaviours: plain indirect, modify after use, modify before use, or an offset that is used but never stored. A flag tells the register file whether the new pointer is to be written back.

Circular addressing can be switched on for a limited group of pointer registers. It keeps the updated pointer inside a naturally aligned power-of-two block. The low bits come from the linear result, and the high bits are kept from the original pointer. Double-word accesses never wrap. The result is held in an output register, so it appears one clock after the inputs. A parameter can remove that register and make the block purely combinational.

Top module: `ptr_addr_gen`

## Requirements
- R1: Mode code 0 (plain) and the unused mode code 7 give an address equal to the base, a new pointer equal to the base, and a write-back flag of 0.
- R2: Mode codes 1 (post-increment) and 2 (post-decrement) give the unmodified base as the address. The new pointer is base plus (code 1) or minus (code 2) the scaled offset, and the write-back flag is 1.
- R3: Mode codes 3 (pre-increment) and 4 (pre-decrement) give base plus or minus the scaled offset as both the address and the new pointer, and the write-back flag is 1.
- R4: Mode codes 5 (offset add) and 6 (offset subtract) give base plus or minus the scaled offset as the address. The new pointer equals the base and the write-back flag is 0.
- R5: The offset is shifted left by the size code before use. Size codes 0, 1, 2 and 3 stand for 1, 2, 4 and 8 bytes.
- R6: Circular wrapping applies only when the circular enable is 1 and the register index is 4, 5, 6 or 7. Any other index updates linearly.
- R7: With wrapping active, result bits below position k come from the linear sum and bits at k and above come from the base. Here k is the block-size exponent clamped to the range 1 to 16, so a value of 0 acts as 1 and values above 16 act as 16.
- R8: Size code 3 (8-byte access) never wraps, even when circular mode is enabled for an eligible register.
- R9: Outputs are registered with one clock of latency, and an active-low reset clears the address, the pointer and the flag to 0.
- R10: Linear arithmetic is modulo 2^32, so a carry or borrow past bit 31 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Current pointer register value |
| ofs_i | input | OFS_W | Unsigned offset in elements |
| size_i | input | 2 | Access size code (log2 of bytes) |
| mode_i | input | 3 | Addressing mode code |
| reg_i | input | 4 | Index of the pointer register within its side |
| circ_en_i | input | 1 | Circular addressing enable for this access |
| blk_log2_i | input | 5 | Circular block size exponent |
| addr_o | output | 32 | Effective byte address |
| ptr_o | output | 32 | New pointer value |
| wb_o | output | 1 | Pointer write-back request |

## Verification
The block keeps no state other than its output register, so any error shows up at the ports one clock after the inputs that cause it, and never later. Three kinds of fault would show at once and are easy to tell apart. A wrong mode decode shows as a write-back flag with the wrong value, or as the address and the pointer being swapped. A wrong scaling shows as a distance from the base that is off by a power of two. A wrong circular mask shows as a difference in the upper bits of the pointer, or as a wrap on an ineligible register or on an 8-byte access. The bench model checks every output on every clock against the vector applied one clock earlier.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [2:0] {
        M_PLAIN    = 3'd0,
        M_POST_INC = 3'd1,
        M_POST_DEC = 3'd2,
        M_PRE_INC  = 3'd3,
        M_PRE_DEC  = 3'd4,
        M_OFS_ADD  = 3'd5,
        M_OFS_SUB  = 3'd6,
        M_RSVD     = 3'd7
    } agen_mode_e;

    localparam logic [1:0] SZ_DBL = 2'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] ptr;
        logic              wb;
    } agen_res_t;
endpackage

// File: rtl/agen_scale.sv
module agen_scale #(
    parameter int OFS_W = 15
) (
    input  logic [OFS_W-1:0]            ofs_i,
    input  logic [1:0]                  size_i,
    output logic [agen_pkg::ADDR_W-1:0] scaled_o
);
    import agen_pkg::*;
    localparam int PAD_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] wide;
    assign wide     = {{PAD_W{1'b0}}, ofs_i};
    assign scaled_o = wide << size_i;
endmodule

// File: rtl/agen_wrap.sv
module agen_wrap #(
    parameter int KW = 5
) (
    input  logic [agen_pkg::ADDR_W-1:0] base_i,
    input  logic [agen_pkg::ADDR_W-1:0] lin_i,
    input  logic                        en_i,
    input  logic [KW-1:0]               k_i,
    output logic [agen_pkg::ADDR_W-1:0] out_o
);
    import agen_pkg::*;
    localparam int CW = KW + 8;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        localparam logic [CW-1:0] IDX = CW'(i);
        logic keep_upper;
        assign keep_upper = en_i && (IDX >= CW'(k_i));
        assign out_o[i]   = keep_upper ? base_i[i] : lin_i[i];
    end
endmodule

// File: rtl/agen_core.sv
module agen_core #(
    parameter int OFS_W        = 15,
    parameter int KW           = 5,
    parameter int BLK_MAX_LOG2 = 16,
    parameter int CIRC_LO      = 4,
    parameter int CIRC_HI      = 7
) (
    input  logic [agen_pkg::ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]            ofs_i,
    input  logic [1:0]                  size_i,
    input  logic [2:0]                  mode_i,
    input  logic [3:0]                  reg_i,
    input  logic                        circ_en_i,
    input  logic [KW-1:0]               blk_log2_i,
    output agen_pkg::agen_res_t         res_d
);
    import agen_pkg::*;
    localparam logic [KW-1:0] K_MIN = KW'(1);
    localparam logic [KW-1:0] K_MAX = KW'(BLK_MAX_LOG2);
    localparam logic [3:0]    R_LO  = 4'(CIRC_LO);
    localparam logic [3:0]    R_HI  = 4'(CIRC_HI);

    logic [ADDR_W-1:0] scaled;
    logic [ADDR_W-1:0] lin     [2];
    logic [ADDR_W-1:0] wrapped [2];
    logic [KW-1:0]     k_eff;
    logic              circ_on;

    agen_scale #(.OFS_W(OFS_W)) u_scale (
        .ofs_i   (ofs_i),
        .size_i  (size_i),
        .scaled_o(scaled)
    );

    assign lin[0] = base_i + scaled;
    assign lin[1] = base_i - scaled;

    always_comb begin
        if (blk_log2_i < K_MIN)      k_eff = K_MIN;
        else if (blk_log2_i > K_MAX) k_eff = K_MAX;
        else                         k_eff = blk_log2_i;
    end

    assign circ_on = circ_en_i && (reg_i >= R_LO) && (reg_i <= R_HI)
                     && (size_i != SZ_DBL);

    for (genvar g = 0; g < 2; g++) begin : g_dir
        agen_wrap #(.KW(KW)) u_wrap (
            .base_i(base_i),
            .lin_i (lin[g]),
            .en_i  (circ_on),
            .k_i   (k_eff),
            .out_o (wrapped[g])
        );
    end

    always_comb begin
        res_d.addr = base_i;
        res_d.ptr  = base_i;
        res_d.wb   = 1'b0;
        case (agen_mode_e'(mode_i))
            M_POST_INC: begin res_d.ptr = wrapped[0]; res_d.wb = 1'b1; end
            M_POST_DEC: begin res_d.ptr = wrapped[1]; res_d.wb = 1'b1; end
            M_PRE_INC: begin
                res_d.addr = wrapped[0];
                res_d.ptr  = wrapped[0];
                res_d.wb   = 1'b1;
            end
            M_PRE_DEC: begin
                res_d.addr = wrapped[1];
                res_d.ptr  = wrapped[1];
                res_d.wb   = 1'b1;
            end
            M_OFS_ADD: res_d.addr = wrapped[0];
            M_OFS_SUB: res_d.addr = wrapped[1];
            default: ;
        endcase
    end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
    parameter int OFS_W        = 15,
    parameter int KW           = 5,
    parameter int BLK_MAX_LOG2 = 16,
    parameter int CIRC_LO      = 4,
    parameter int CIRC_HI      = 7,
    parameter bit REG_OUT      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      base_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [1:0]       size_i,
    input  logic [2:0]       mode_i,
    input  logic [3:0]       reg_i,
    input  logic             circ_en_i,
    input  logic [KW-1:0]    blk_log2_i,
    output logic [31:0]      addr_o,
    output logic [31:0]      ptr_o,
    output logic             wb_o
);
    import agen_pkg::*;

    agen_res_t res_d;
    agen_res_t res_q;

    agen_core #(
        .OFS_W(OFS_W), .KW(KW), .BLK_MAX_LOG2(BLK_MAX_LOG2),
        .CIRC_LO(CIRC_LO), .CIRC_HI(CIRC_HI)
    ) u_core (
        .base_i    (base_i),
        .ofs_i     (ofs_i),
        .size_i    (size_i),
        .mode_i    (mode_i),
        .reg_i     (reg_i),
        .circ_en_i (circ_en_i),
        .blk_log2_i(blk_log2_i),
        .res_d     (res_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    if (REG_OUT) begin : g_reg
        assign addr_o = res_q.addr;
        assign ptr_o  = res_q.ptr;
        assign wb_o   = res_q.wb;

        a_r1_plain_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == 3'd0 || mode_i == 3'd7)
            |=> (!wb_o && addr_o == $past(base_i) && ptr_o == $past(base_i)));

        a_r2_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == 3'd1 || mode_i == 3'd2) |=> (wb_o && addr_o == $past(base_i)));

        a_r3_pre_match: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == 3'd3 || mode_i == 3'd4) |=> (wb_o && addr_o == ptr_o));

        a_r4_offset_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == 3'd5 || mode_i == 3'd6) |=> (!wb_o && ptr_o == $past(base_i)));

        a_r7_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
            (circ_en_i && reg_i >= 4'(CIRC_LO) && reg_i <= 4'(CIRC_HI) && size_i != 2'd3)
            |=> ((ptr_o ^ $past(base_i)) >> BLK_MAX_LOG2) == 32'd0);

        a_r8_dbl_step: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == 3'd1 && size_i == 2'd3)
            |=> (ptr_o == $past(base_i) + ({17'd0, $past(ofs_i)} << 3)));
    end else begin : g_comb
        assign addr_o = res_d.addr;
        assign ptr_o  = res_d.ptr;
        assign wb_o   = res_d.wb;
    end
endmodule

// File: tb/sim_ptr_addr_gen.sv
`timescale 1ns/1ps
module sim_ptr_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [14:0] ofs_i = '0;
    logic [1:0]  size_i = '0;
    logic [2:0]  mode_i = '0;
    logic [3:0]  reg_i = '0;
    logic        circ_en_i = 1'b0;
    logic [4:0]  blk_log2_i = '0;
    logic [31:0] addr_o, ptr_o;
    logic        wb_o;

    int checks = 0;
    int errors = 0;
    logic [64:0] exp_v;
    string       exp_tag;

    always #4 clk = ~clk;

    ptr_addr_gen u0 (.*);

    function automatic logic [64:0] model(input logic [31:0] b, input logic [14:0] o,
            input logic [1:0] sz, input logic [2:0] m, input logic [3:0] r,
            input logic ce, input logic [4:0] bl);
        longint unsigned step, plus, minus, mask, a, p;
        int k;
        bit circ, w;
        step  = longint'(o) * (longint'(1) << sz);
        plus  = (longint'(b) + step) % 64'h1_0000_0000;
        minus = (longint'(b) + 64'h1_0000_0000 - step) % 64'h1_0000_0000;
        k = (bl == 0) ? 1 : (bl > 16) ? 16 : int'(bl);
        mask = (longint'(1) << k) - 1;
        circ = ce && r >= 4 && r <= 7 && sz != 3;
        if (circ) begin
            plus  = (longint'(b) & ~mask & 64'hFFFF_FFFF) | (plus & mask);
            minus = (longint'(b) & ~mask & 64'hFFFF_FFFF) | (minus & mask);
        end
        a = b; p = b; w = 0;
        case (m)
            1: begin p = plus;  w = 1; end
            2: begin p = minus; w = 1; end
            3: begin a = plus;  p = plus;  w = 1; end
            4: begin a = minus; p = minus; w = 1; end
            5: a = plus;
            6: a = minus;
            default: ;
        endcase
        return {w, a[31:0], p[31:0]};
    endfunction

    task automatic check(input string tag);
        checks++;
        if ({wb_o, addr_o, ptr_o} !== exp_v) begin
            errors++;
            $display("FAIL %s: got wb=%0b addr=%08h ptr=%08h, expected wb=%0b addr=%08h ptr=%08h",
                     tag, wb_o, addr_o, ptr_o, exp_v[64], exp_v[63:32], exp_v[31:0]);
        end
    endtask

    // called at a negedge; checks at the next negedge (one register of latency)
    task automatic vec(input string tag, input logic [31:0] b, input logic [14:0] o,
            input logic [1:0] sz, input logic [2:0] m, input logic [3:0] r,
            input logic ce, input logic [4:0] bl);
        base_i = b; ofs_i = o; size_i = sz; mode_i = m; reg_i = r;
        circ_en_i = ce; blk_log2_i = bl;
        exp_v = model(b, o, sz, m, r, ce, bl);
        exp_tag = tag;
        @(negedge clk);
        check(exp_tag);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        base_i = 32'hDEAD_BEEF; mode_i = 3'd3; ofs_i = 15'd7;
        repeat (3) @(negedge clk);
        exp_v = '0;
        check("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        vec("R1 plain",        32'h1000_0040, 15'd9, 2'd2, 3'd0, 4'd1, 1'b0, 5'd4);
        vec("R1 reserved",     32'h1000_0044, 15'd9, 2'd2, 3'd7, 4'd5, 1'b1, 5'd4);
        vec("R2 post-inc",     32'h0000_0100, 15'd3, 2'd2, 3'd1, 4'd0, 1'b0, 5'd0);
        vec("R2 post-dec",     32'h0000_0100, 15'd3, 2'd1, 3'd2, 4'd0, 1'b0, 5'd0);
        vec("R3 pre-inc",      32'h0000_0100, 15'd5, 2'd1, 3'd3, 4'd2, 1'b0, 5'd0);
        vec("R3 pre-dec",      32'h0000_0100, 15'd5, 2'd0, 3'd4, 4'd2, 1'b0, 5'd0);
        vec("R4 offset add",   32'h0000_2000, 15'd4, 2'd2, 3'd5, 4'd6, 1'b0, 5'd0);
        vec("R4 offset sub",   32'h0000_2000, 15'd4, 2'd2, 3'd6, 4'd6, 1'b0, 5'd0);
        for (int s = 0; s < 4; s++)
            vec("R5 scale", 32'h0000_1000, 15'd1, 2'(s), 3'd3, 4'd0, 1'b0, 5'd0);
        vec("R5 max offset",   32'h0000_0000, 15'h7FFF, 2'd3, 3'd1, 4'd0, 1'b0, 5'd0);
        vec("R6 reg3 linear",  32'h2000_001C, 15'd2, 2'd2, 3'd3, 4'd3, 1'b1, 5'd4);
        vec("R6 reg8 linear",  32'h2000_001C, 15'd2, 2'd2, 3'd3, 4'd8, 1'b1, 5'd4);
        vec("R6 reg4 wraps",   32'h2000_001C, 15'd2, 2'd2, 3'd3, 4'd4, 1'b1, 5'd4);
        vec("R6 disabled",     32'h2000_001C, 15'd2, 2'd2, 3'd3, 4'd4, 1'b0, 5'd4);
        vec("R7 post-dec wrap",32'h3000_0004, 15'd2, 2'd2, 3'd2, 4'd7, 1'b1, 5'd5);
        vec("R7 k0 clamp",     32'h0000_0001, 15'd1, 2'd0, 3'd1, 4'd5, 1'b1, 5'd0);
        vec("R7 k20 clamp",    32'h1234_FFF0, 15'd8, 2'd2, 3'd3, 4'd6, 1'b1, 5'd20);
        vec("R7 offset wrap",  32'h0000_00F8, 15'd4, 2'd2, 3'd5, 4'd6, 1'b1, 5'd8);
        vec("R8 dbl linear",   32'h2000_001C, 15'd2, 2'd3, 3'd3, 4'd5, 1'b1, 5'd4);
        vec("R8 dbl post",     32'h4000_00F8, 15'd1, 2'd3, 3'd1, 4'd4, 1'b1, 5'd3);
        vec("R10 overflow",    32'hFFFF_FFFC, 15'd1, 2'd2, 3'd1, 4'd0, 1'b0, 5'd0);
        vec("R10 underflow",   32'h0000_0002, 15'd1, 2'd2, 3'd4, 4'd0, 1'b0, 5'd0);
        for (int n = 0; n < 400; n++) begin
            logic [2:0] m;
            string t;
            m = 3'($urandom_range(0, 7));
            case (m)
                3'd1, 3'd2: t = "R2 random";
                3'd3, 3'd4: t = "R3 random";
                3'd5, 3'd6: t = "R4 random";
                default:    t = "R1 random";
            endcase
            vec(t, $urandom, 15'($urandom), 2'($urandom), m, 4'($urandom),
                1'($urandom), 5'($urandom_range(0, 20)));
        end
        // R9: asynchronous reset clears the registered result
        rst_n = 1'b0;
        #1;
        exp_v = '0;
        check("R9 async reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule